// File: doc/BRIEF.md
# Parallel Flash Read-Path Controller

This block models the read side of a 16-bit parallel NOR flash as synchronous logic clocked by a fast system clock. It holds a small ROM array and serves reads from it in one of two modes. A mode bit in a configuration register selects the mode, and that bit resets to the asynchronous page mode. In page mode the flash clock input has no effect. A page miss fetches four words together into a page buffer after a parameterised access delay, and the two lowest address bits then pick the word on the data bus. In burst mode the flash clock input is sampled, and each of its rising edges counts as a valid edge. The address is latched on a valid edge while the address-valid strobe is low. After a programmable latency, one word per valid edge streams out from linearly incrementing addresses, and a WAIT output covers the latency.

Written commands (a rising edge of the write strobe while the chip enable is low) move a read state between array, identifier, status and query. They also load the configuration through a two-write setup/confirm sequence that takes its value from the address bus. Identifier, status and query reads return constant words in place of array data. The output enable flag stands for the data bus being driven.

Top module: `flash_read_ctrl`

## Requirements
- R1: After `rst`, or while `dev_rst_n` is low, the block returns to the array read state, asynchronous page mode and burst latency 3. `wait_o` is 0, and an array read needs no command first.
- R2: In page mode, array word at address a is {a[7:0], ~a[7:0]}. It appears on `dq_out` after a page miss once the access delay of ACC_CYC cycles has passed (bench waits ACC_CYC+10 cycles).
- R3: In page mode, an address inside the already loaded page (same bits above bit 1) drives its word on `dq_out` at the second system clock edge after it is presented with `adv_n` low.
- R4: In page mode, `wait_o` stays 0 and toggling `flash_clk` leaves `dq_out` unchanged.
- R5: The address is transparent while `adv_n` is low and held while it is high. Address changes made while `adv_n` is high do not change `dq_out`.
- R6: Commands 0x0090, 0x0070, 0x0098 and 0x00FF select the identifier, status, query and array states. Identifier returns 0x00A7 for even and 0x1C3E for odd addresses. Status returns 0x0080. Query returns 0x0040 + a[2:0].
- R7: Any other command, including a setup not followed by confirm, selects the status state. Array data returns only after 0x00FF.
- R8: Writing 0x0060 then 0x0003 loads the configuration from the address of the second write. Bit 15 set means page mode and clear means burst mode. Bits 13:11 hold the latency N.
- R9: In burst mode, a valid edge with `adv_n` and `ce_n` low latches the address and raises `wait_o`. The first word appears at the Nth following valid edge, N=0 acting as 1, and `wait_o` drops at that same edge.
- R10: Each further valid edge in a burst outputs the next address's word, counting linearly and continuing across page boundaries.
- R11: `dq_oe` is 1 one cycle after `ce_n` and `oe_n` are low with `we_n` high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_rst_n | input | 1 | Device reset, active low, sampled on clk |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, command taken on its rising edge |
| adv_n | input | 1 | Address valid, active low |
| flash_clk | input | 1 | Burst clock, rising edges are valid edges |
| addr | input | AW | Word address, also configuration value |
| din | input | 16 | Command word |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data bus driven |
| wait_o | output | 1 | Burst data not yet valid |

## Verification
The assertions take for granted that each phase of `flash_clk` lasts at least two system clocks. Under that condition every valid edge is seen exactly once and the bank read for the next burst word has settled before that word is needed. They also assume that `we_n` pulses come with `ce_n` low and `din` stable. The stimulus keeps each flash clock phase three system clocks long and holds `din` and the address steady across every write pulse. All inputs change on falling system clock edges only.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_IDENT  = 2'd1,
    RS_STATUS = 2'd2,
    RS_QUERY  = 2'd3
  } rd_state_e;

  localparam logic [15:0] CMD_ARRAY   = 16'h00FF;
  localparam logic [15:0] CMD_IDENT   = 16'h0090;
  localparam logic [15:0] CMD_STATUS  = 16'h0070;
  localparam logic [15:0] CMD_QUERY   = 16'h0098;
  localparam logic [15:0] CMD_SETUP   = 16'h0060;
  localparam logic [15:0] CMD_CONFIRM = 16'h0003;

  localparam int          LAT_W        = 3;
  localparam logic        CFG_ASYNC_RV = 1'b1;
  localparam logic [2:0]  CFG_LAT_RV   = 3'd3;
  localparam logic [15:0] STATUS_READY = 16'h0080;

  function automatic logic [15:0] array_word(input logic [7:0] idx);
    return {idx, ~idx};
  endfunction

  function automatic logic [15:0] side_word(input rd_state_e st, input logic [2:0] a);
    case (st)
      RS_IDENT:  return a[0] ? 16'h1C3E : 16'h00A7;
      RS_STATUS: return STATUS_READY;
      RS_QUERY:  return 16'h0040 + {13'd0, a};
      default:   return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/flash_bank_rom.sv
module flash_bank_rom
  import flash_rd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int ROWS  = DEPTH / 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic [ROW_W-1:0] row,
  output logic [3:0][15:0] q
);
  generate
    for (genvar b = 0; b < 4; b++) begin : g_bank
      logic [15:0] mem [ROWS];
      logic [15:0] q_b;
      initial begin
        for (int r = 0; r < ROWS; r++) mem[r] = array_word(8'(r * 4 + b));
      end
      always_ff @(posedge clk) q_b <= mem[row];
      assign q[b] = q_b;
    end
  endgenerate
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_stb,
  input  logic [15:0]      cmd,
  input  logic             cfg_async_in,
  input  logic [LAT_W-1:0] cfg_lat_in,
  output rd_state_e        state,
  output logic             cfg_async,
  output logic [LAT_W-1:0] cfg_lat
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RS_ARRAY;
      cfg_async <= CFG_ASYNC_RV;
      cfg_lat   <= CFG_LAT_RV;
      pend      <= 1'b0;
    end else if (cmd_stb) begin
      pend <= 1'b0;
      if (pend) begin
        if (cmd == CMD_CONFIRM) begin
          cfg_async <= cfg_async_in;
          cfg_lat   <= cfg_lat_in;
        end else begin
          state <= RS_STATUS;
        end
      end else begin
        case (cmd)
          CMD_ARRAY:  state <= RS_ARRAY;
          CMD_IDENT:  state <= RS_IDENT;
          CMD_STATUS: state <= RS_STATUS;
          CMD_QUERY:  state <= RS_QUERY;
          CMD_SETUP:  pend  <= 1'b1;
          default:    state <= RS_STATUS;
        endcase
      end
    end
  end

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == RS_ARRAY && cfg_async && cfg_lat == CFG_LAT_RV));

  assert_array_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !pend && cmd == CMD_ARRAY) |=> state == RS_ARRAY);
endmodule

// File: rtl/flash_page_read.sv
module flash_page_read #(
  parameter int AW      = 16,
  parameter int ACC_CYC = 4,
  localparam int CW     = $clog2(ACC_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  input  logic [3:0][15:0] bank_q,
  input  logic             is_array,
  input  logic [15:0]      side_in,
  output logic [AW-1:0]    eff_addr,
  output logic [15:0]      dq
);
  logic [3:0][15:0] page_buf;
  logic [AW-3:0]    page_tag, fetch_tag;
  logic             page_valid, busy;
  logic [CW-1:0]    fcnt;
  logic [AW-3:0]    cur_tag;
  logic             hit;

  assign cur_tag = eff_addr[AW-1:2];
  assign hit     = page_valid && (page_tag == cur_tag);

  always_ff @(posedge clk) begin
    if (rst) eff_addr <= '0;
    else if (!adv_n) eff_addr <= addr;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy       <= 1'b0;
      page_valid <= 1'b0;
      fcnt       <= '0;
      fetch_tag  <= '0;
      page_tag   <= '0;
    end else if (busy) begin
      if (cur_tag != fetch_tag) begin
        fcnt      <= CW'(ACC_CYC);
        fetch_tag <= cur_tag;
      end else if (fcnt == '0) begin
        busy       <= 1'b0;
        page_tag   <= fetch_tag;
        page_valid <= 1'b1;
      end else begin
        fcnt <= fcnt - 1'b1;
      end
    end else if (!hit) begin
      busy      <= 1'b1;
      fcnt      <= CW'(ACC_CYC);
      fetch_tag <= cur_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (busy && cur_tag == fetch_tag && fcnt == '0) page_buf <= bank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) dq <= '0;
    else if (!is_array) dq <= side_in;
    else if (hit) dq <= page_buf[eff_addr[1:0]];
  end

  assert_fetch_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(page_valid) |-> $past(busy));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    adv_n |=> eff_addr == $past(eff_addr));
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import flash_rd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fedge,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  input  logic [LAT_W-1:0] lat,
  input  logic [15:0]      word_in,
  output logic [AW-1:0]    baddr,
  output logic [15:0]      dq,
  output logic             wait_o
);
  logic             active;
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      wait_o <= 1'b0;
      cnt    <= '0;
      baddr  <= '0;
      dq     <= '0;
    end else if (!en || ce_n) begin
      active <= 1'b0;
      wait_o <= 1'b0;
    end else if (fedge) begin
      if (!adv_n) begin
        baddr  <= addr;
        cnt    <= (lat == '0) ? LAT_W'(1) : lat;
        active <= 1'b1;
        wait_o <= 1'b1;
      end else if (active) begin
        if (cnt > LAT_W'(1)) begin
          cnt <= cnt - 1'b1;
        end else begin
          dq     <= word_in;
          baddr  <= baddr + 1'b1;
          wait_o <= 1'b0;
        end
      end
    end
  end

  assert_wait_async_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wait_o);

  assert_wait_edge_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(wait_o) && !$past(rst) && $past(en && !ce_n)) |-> $past(fedge));
endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
  import flash_rd_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DEPTH   = 256,
  parameter int ACC_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic          flash_clk,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   din,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  output logic          wait_o
);
  localparam int ROW_W = $clog2(DEPTH / 4);

  logic             blk_rst;
  logic             we_q, fclk_s, fclk_q, fedge, cmd_stb;
  rd_state_e        state;
  logic             async_mode;
  logic [LAT_W-1:0] lat;
  logic [3:0][15:0] bank_q;
  logic [ROW_W-1:0] rd_row;
  logic [AW-1:0]    eff_addr, baddr;
  logic [15:0]      a_dq, b_dq, a_side, b_word;

  assign blk_rst = rst || !dev_rst_n;

  always_ff @(posedge clk) begin
    if (blk_rst) begin
      we_q   <= 1'b1;
      fclk_s <= 1'b0;
      fclk_q <= 1'b0;
      dq_oe  <= 1'b0;
    end else begin
      we_q   <= we_n;
      fclk_s <= flash_clk;
      fclk_q <= fclk_s;
      dq_oe  <= !ce_n && !oe_n && we_n;
    end
  end

  assign fedge   = fclk_s && !fclk_q;
  assign cmd_stb = we_n && !we_q && !ce_n;

  flash_cmd_decode u_dec (
    .clk(clk), .rst(blk_rst), .cmd_stb(cmd_stb), .cmd(din),
    .cfg_async_in(addr[15]), .cfg_lat_in(addr[13:11]),
    .state(state), .cfg_async(async_mode), .cfg_lat(lat)
  );

  assign rd_row = async_mode ? eff_addr[ROW_W+1:2] : baddr[ROW_W+1:2];

  flash_bank_rom #(.DEPTH(DEPTH)) u_rom (.clk(clk), .row(rd_row), .q(bank_q));

  assign a_side = side_word(state, eff_addr[2:0]);
  assign b_word = (state == RS_ARRAY) ? bank_q[baddr[1:0]] : side_word(state, baddr[2:0]);

  flash_page_read #(.AW(AW), .ACC_CYC(ACC_CYC)) u_page (
    .clk(clk), .rst(blk_rst), .en(async_mode), .adv_n(adv_n), .addr(addr),
    .bank_q(bank_q), .is_array(state == RS_ARRAY), .side_in(a_side),
    .eff_addr(eff_addr), .dq(a_dq)
  );

  flash_burst_seq #(.AW(AW)) u_burst (
    .clk(clk), .rst(blk_rst), .en(!async_mode), .fedge(fedge), .ce_n(ce_n),
    .adv_n(adv_n), .addr(addr), .lat(lat), .word_in(b_word),
    .baddr(baddr), .dq(b_dq), .wait_o(wait_o)
  );

  assign dq_out = async_mode ? a_dq : b_dq;

  assert_oe_ce_R11: assert property (@(posedge clk) disable iff (blk_rst)
    ce_n |=> !dq_oe);
endmodule

// File: tb/flash_read_ctrl_tb.sv
module flash_read_ctrl_tb_top;
  localparam int AW = 16, ACC = 4;

  logic clk = 1'b0, rst = 1'b1, dev_rst_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b0, we_n = 1'b1, adv_n = 1'b1, flash_clk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq_out;
  logic dq_oe, wait_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_read_ctrl #(.AW(AW), .DEPTH(256), .ACC_CYC(ACC)) dut_i (
    .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .adv_n(adv_n), .flash_clk(flash_clk), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o)
  );

  localparam logic [15:0] ADDR_VEC [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                                          16'h0044, 16'h00FF, 16'h0100, 16'hABCD};

  function automatic logic [15:0] exp_word(input logic [15:0] a);
    return {a[7:0], ~a[7:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_cmd(input logic [15:0] c, input logic [15:0] a);
    @(negedge clk); ce_n = 0; addr = a; din = c; we_n = 0;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic aread(input logic [15:0] a);
    @(negedge clk); addr = a; adv_n = 0;
    @(negedge clk); adv_n = 1;
    repeat (ACC + 10) @(negedge clk);
  endtask

  task automatic ftick();
    @(negedge clk); flash_clk = 1;
    repeat (3) @(negedge clk); flash_clk = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {15'd0, dq_oe}, 16'd0);
    chk("R1 wait", {15'd0, wait_o}, 16'd0);
    ce_n = 0;
    // R2 vector walk, page mode array reads
    foreach (ADDR_VEC[i]) begin
      aread(ADDR_VEC[i]);
      chk("R2 array read", dq_out, exp_word(ADDR_VEC[i]));
    end
    // R11 output enable
    chk("R11 oe on", {15'd0, dq_oe}, 16'd1);
    @(negedge clk); oe_n = 1; repeat (2) @(negedge clk);
    chk("R11 oe off by oe_n", {15'd0, dq_oe}, 16'd0);
    oe_n = 0; ce_n = 1; repeat (2) @(negedge clk);
    chk("R11 oe off by ce_n", {15'd0, dq_oe}, 16'd0);
    ce_n = 0;
    // R3 page hit timing
    aread(16'h0010);
    @(negedge clk); addr = 16'h0013; adv_n = 0;
    @(negedge clk); adv_n = 1;
    @(negedge clk);
    chk("R3 page hit", dq_out, exp_word(16'h0013));
    // R5 address held while adv_n high
    @(negedge clk); addr = 16'h0077; repeat (ACC + 10) @(negedge clk);
    chk("R5 hold", dq_out, exp_word(16'h0013));
    // R4 flash clock ignored in page mode
    ftick(); ftick();
    chk("R4 dq", dq_out, exp_word(16'h0013));
    chk("R4 wait", {15'd0, wait_o}, 16'd0);
    // R6 read states
    wr_cmd(16'h0090, 16'h0000);
    aread(16'h0000); chk("R6 ident even", dq_out, 16'h00A7);
    aread(16'h0001); chk("R6 ident odd", dq_out, 16'h1C3E);
    wr_cmd(16'h0070, 16'h0000);
    aread(16'h0005); chk("R6 status", dq_out, 16'h0080);
    wr_cmd(16'h0098, 16'h0000);
    aread(16'h0005); chk("R6 query", dq_out, 16'h0045);
    wr_cmd(16'h00FF, 16'h0000);
    aread(16'h0021); chk("R6 array", dq_out, exp_word(16'h0021));
    // R7 non-read command
    wr_cmd(16'h0040, 16'h0000);
    aread(16'h0022); chk("R7 after other cmd", dq_out, 16'h0080);
    wr_cmd(16'h0060, 16'h0000); wr_cmd(16'h00FF, 16'h0000);
    aread(16'h0023); chk("R7 broken setup", dq_out, 16'h0080);
    wr_cmd(16'h00FF, 16'h0000);
    aread(16'h0024); chk("R7 array back", dq_out, exp_word(16'h0024));
    // R8 R9 R10 burst, latency 4, crossing page and index wrap
    wr_cmd(16'h0060, 16'h2000); wr_cmd(16'h0003, 16'h2000);
    @(negedge clk); addr = 16'h00FE; adv_n = 0;
    ftick(); adv_n = 1;
    chk("R9 wait after latch", {15'd0, wait_o}, 16'd1);
    for (int k = 1; k < 4; k++) begin
      ftick();
      chk("R9 wait in latency", {15'd0, wait_o}, 16'd1);
    end
    ftick();
    chk("R9 first word", dq_out, exp_word(16'h00FE));
    chk("R9 wait low", {15'd0, wait_o}, 16'd0);
    ftick(); chk("R10 second", dq_out, exp_word(16'h00FF));
    ftick(); chk("R10 third", dq_out, exp_word(16'h0100));
    ftick(); chk("R10 fourth", dq_out, exp_word(16'h0101));
    // R9 latency 0 behaves as 1
    wr_cmd(16'h0060, 16'h0000); wr_cmd(16'h0003, 16'h0000);
    @(negedge clk); addr = 16'h0031; adv_n = 0;
    ftick(); adv_n = 1;
    chk("R9 lat0 wait", {15'd0, wait_o}, 16'd1);
    ftick(); chk("R9 lat0 word", dq_out, exp_word(16'h0031));
    // R8 back to page mode
    wr_cmd(16'h0060, 16'h9800); wr_cmd(16'h0003, 16'h9800);
    chk("R8 wait page", {15'd0, wait_o}, 16'd0);
    aread(16'h0055); chk("R8 page read", dq_out, exp_word(16'h0055));
    // R12-style device reset, checked under R1
    wr_cmd(16'h0060, 16'h0000); wr_cmd(16'h0003, 16'h0000);
    wr_cmd(16'h0090, 16'h0000);
    @(negedge clk); dev_rst_n = 0; repeat (2) @(negedge clk); dev_rst_n = 1;
    chk("R1 dev reset wait", {15'd0, wait_o}, 16'd0);
    aread(16'h0066); chk("R1 dev reset array", dq_out, exp_word(16'h0066));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule